// File: doc/BRIEF.md
# Address-Window Trace Message Encoder

This block turns ordinary stores into trace messages. It watches a memory-mapped write port for stores that land inside a 1 MB trace window. The window is made of 256 channel pages of 4 KB each, so a memory management unit can enable or disable a channel by mapping or unmapping one page. The address alone decides the message. Bits [19:12] give the channel. Bit 11 picks the source CPU. Bit 10 marks the message as timestamped. The store's size and data complete the message. Each accepted store becomes one message, made of a 12-bit header, a 32-bit payload and a timestamp field that is always zero. The message goes into a small FIFO, and a ready/valid drain side pops it.

Message generation is gated in four ways:
- Each CPU has its own enable.
- Stores flagged as coming from the debugger pass only when a debugger-trace enable is set.
- Nothing passes while no owner holds the claim.
- A store that finds the FIFO full is dropped, and a sticky overflow flag is raised that software can clear.

Releasing the claim stops new messages. Messages already queued still drain.

Top module: `trace_win_encoder`

## Requirements
- R1: A store produces a message only when wr_addr[31:20] equals the window base bits [31:20] (default 0x546). Stores outside the window produce no message.
- R2: The header is {kind, cpu, size[1:0], channel[7:0]} with kind in bit 11. Channel is wr_addr[19:12]. The cpu bit is wr_addr[11] (0 = CPU1, 1 = CPU2). The kind bit is wr_addr[10] (1 = timestamped).
- R3: The size code is 00 for 1 byte, 01 for 2 bytes and 10 for 4 bytes. The payload is the low 8 or 16 bits of wr_data, zero-extended, or all 32 bits. A store with size code 11 produces no message.
- R4: When cpu1_en is low, a store with bit 11 clear produces no message. When cpu2_en is low, a store with bit 11 set produces no message.
- R5: A store with wr_from_dbg high produces a message only when dbg_trace_en is high. That message is identical to the one an application store to the same address would produce.
- R6: msg_tstamp is zero for every message, timestamped or not.
- R7: While no owner holds the claim, stores produce no message. claim_req takes ownership only when it is free. claim_release frees it. dbg_disconnect frees only a debugger-held claim. dbg_halted never changes ownership.
- R8: Messages queued before a release are still delivered, in order, after the release.
- R9: Messages leave in the order they were accepted. The FIFO holds DEPTH entries (default 8). A store that arrives while the FIFO is full is dropped, even if a pop happens in the same cycle. That store sets ovf_flag, which stays set until ovf_clear is asserted. If a set and a clear come in the same cycle, the set wins.
- R10: After reset, msg_valid, owned, owner_is_dbg and ovf_flag are low. msg_valid stays high, with stable header and data, until msg_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store present this cycle |
| wr_addr | input | 32 | Store byte address |
| wr_data | input | 32 | Store data, low lanes used for narrow stores |
| wr_size | input | 2 | Size code: 00 byte, 01 halfword, 10 word |
| wr_from_dbg | input | 1 | Store was issued by the debugger |
| cpu1_en | input | 1 | Enable CPU1 message generation |
| cpu2_en | input | 1 | Enable CPU2 message generation |
| dbg_trace_en | input | 1 | Let debugger stores generate messages |
| claim_req | input | 1 | Request ownership |
| claim_is_dbg | input | 1 | Claim requested by the debugger |
| claim_release | input | 1 | Release ownership |
| dbg_disconnect | input | 1 | Debugger disconnected |
| dbg_halted | input | 1 | Processor in debug state (no effect) |
| ovf_clear | input | 1 | Clear the overflow flag |
| owned | output | 1 | An owner holds the claim |
| owner_is_dbg | output | 1 | The owner is the debugger |
| ovf_flag | output | 1 | Sticky overflow flag |
| msg_valid | output | 1 | A message is available |
| msg_ready | input | 1 | Drain side takes the message |
| msg_hdr | output | 12 | Message header |
| msg_data | output | 32 | Message payload |
| msg_tstamp | output | 16 | Timestamp field, always zero |

## Verification
Some properties are checked on every cycle:
- the timestamp field is zero;
- no size code 11 reaches the output, and byte payloads are zero above bit 7;
- a message waiting for msg_ready holds still;
- the overflow flag is sticky;
- ownership is unchanged when no claim, release or disconnect is presented;
- an empty FIFO stays empty while nothing is owned or both CPUs are disabled.

Other behaviour can only be shown by the bench's scenarios. These cover the exact header and payload for each address quarter and size, rejection outside the window, the debugger gate, and the drop of a store that meets a full FIFO. They also cover draining after a release and the rule that a disconnect leaves an application claim in place.

// File: rtl/trace_win_pkg.sv
package trace_win_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int CHAN_W    = 8;
    localparam int PAGE_LSB  = 12;
    localparam int WIN_LSB   = PAGE_LSB + CHAN_W;
    localparam int CPU_BIT   = 11;
    localparam int KIND_BIT  = 10;
    localparam int TS_W      = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_APP  = 2'b01,
        OWN_DBG  = 2'b10
    } owner_e;

    typedef struct packed {
        logic              kind;
        logic              cpu;
        size_e             size;
        logic [CHAN_W-1:0] chan;
    } hdr_t;

    localparam int HDR_W = $bits(hdr_t);

    typedef struct packed {
        hdr_t              hdr;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   ts;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    function automatic logic [DATA_W-1:0] lane_zext(input logic [DATA_W-1:0] d,
                                                    input size_e sz);
        logic [DATA_W-1:0] r;
        r = '0;
        case (sz)
            SZ_BYTE: r[7:0]  = d[7:0];
            SZ_HALF: r[15:0] = d[15:0];
            default: r       = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trace_win_decode.sv
module trace_win_decode
    import trace_win_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h5460_0000
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_size,
    input  logic              wr_from_dbg,
    input  logic              cpu1_en,
    input  logic              cpu2_en,
    input  logic              dbg_trace_en,
    input  logic              owned,
    output logic              hit,
    output entry_t            entry
);
    localparam int TAG_W = ADDR_W - WIN_LSB;

    logic  in_win;
    logic  cpu_ok;
    logic  src_ok;
    size_e sz;

    always_comb begin
        sz     = size_e'(wr_size);
        in_win = (wr_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
        cpu_ok = wr_addr[CPU_BIT] ? cpu2_en : cpu1_en;
        src_ok = !wr_from_dbg || dbg_trace_en;
        hit    = wr_valid && in_win && (sz != SZ_BAD) && owned && cpu_ok && src_ok;

        entry.hdr.kind = wr_addr[KIND_BIT];
        entry.hdr.cpu  = wr_addr[CPU_BIT];
        entry.hdr.size = sz;
        entry.hdr.chan = wr_addr[PAGE_LSB +: CHAN_W];
        entry.data     = lane_zext(wr_data, sz);
        entry.ts       = '0;
    end

    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = '0;

endmodule

// File: rtl/trace_win_claim.sv
module trace_win_claim
    import trace_win_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic claim_req,
    input  logic claim_is_dbg,
    input  logic claim_release,
    input  logic dbg_disconnect,
    output owner_e owner
);
    owner_e owner_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
        end else begin
            case (owner_q)
                OWN_NONE: if (claim_req)
                              owner_q <= claim_is_dbg ? OWN_DBG : OWN_APP;
                OWN_APP:  if (claim_release)
                              owner_q <= OWN_NONE;
                OWN_DBG:  if (claim_release || dbg_disconnect)
                              owner_q <= OWN_NONE;
                default:  owner_q <= OWN_NONE;
            endcase
        end
    end

    assign owner = owner_q;

endmodule

// File: rtl/trace_win_fifo.sv
module trace_win_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/trace_win_encoder.sv
module trace_win_encoder
    import trace_win_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h5460_0000,
    parameter int          DEPTH    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [31:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  wr_size,
    input  logic        wr_from_dbg,
    input  logic        cpu1_en,
    input  logic        cpu2_en,
    input  logic        dbg_trace_en,
    input  logic        claim_req,
    input  logic        claim_is_dbg,
    input  logic        claim_release,
    input  logic        dbg_disconnect,
    input  logic        dbg_halted,
    input  logic        ovf_clear,
    output logic        owned,
    output logic        owner_is_dbg,
    output logic        ovf_flag,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [11:0] msg_hdr,
    output logic [31:0] msg_data,
    output logic [15:0] msg_tstamp
);
    owner_e owner;
    logic   hit;
    entry_t new_entry;
    entry_t head_entry;
    logic   fifo_empty, fifo_full;
    logic   ovf_q;

    trace_win_claim u_claim (
        .clk            (clk),
        .rst            (rst),
        .claim_req      (claim_req),
        .claim_is_dbg   (claim_is_dbg),
        .claim_release  (claim_release),
        .dbg_disconnect (dbg_disconnect),
        .owner          (owner)
    );

    assign owned        = (owner != OWN_NONE);
    assign owner_is_dbg = (owner == OWN_DBG);

    trace_win_decode #(.WIN_BASE(WIN_BASE)) u_decode (
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_size      (wr_size),
        .wr_from_dbg  (wr_from_dbg),
        .cpu1_en      (cpu1_en),
        .cpu2_en      (cpu2_en),
        .dbg_trace_en (dbg_trace_en),
        .owned        (owned),
        .hit          (hit),
        .entry        (new_entry)
    );

    trace_win_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (hit),
        .push_data (new_entry),
        .pop       (msg_ready),
        .head      (head_entry),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    always_ff @(posedge clk) begin
        if (rst)                   ovf_q <= 1'b0;
        else if (hit && fifo_full) ovf_q <= 1'b1;
        else if (ovf_clear)        ovf_q <= 1'b0;
    end

    assign ovf_flag   = ovf_q;
    assign msg_valid  = !fifo_empty;
    assign msg_hdr    = head_entry.hdr;
    assign msg_data   = head_entry.data;
    assign msg_tstamp = head_entry.ts;

    logic unused_halt;
    assign unused_halt = dbg_halted;

endmodule

// File: rtl/trace_win_checker.sv
module trace_win_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic [1:0]  wr_size,
    input logic        cpu1_en,
    input logic        cpu2_en,
    input logic        claim_req,
    input logic        claim_release,
    input logic        dbg_disconnect,
    input logic        ovf_clear,
    input logic        owned,
    input logic        owner_is_dbg,
    input logic        ovf_flag,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [11:0] msg_hdr,
    input logic [31:0] msg_data,
    input logic [15:0] msg_tstamp
);
    p_ts_zero_r6: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_tstamp == 16'h0));

    p_no_bad_size_r3: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_hdr[9:8] != 2'b11));

    p_byte_zext_r3: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_hdr[9:8] == 2'b00) |-> (msg_data[31:8] == 24'h0));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_hdr) && $stable(msg_data)));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clear) |=> ovf_flag);

    p_no_owner_r7: assert property (@(posedge clk) disable iff (rst)
        (!owned && !msg_valid) |=> !msg_valid);

    p_owner_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!claim_req && !claim_release && !dbg_disconnect) |=> ($stable(owned) && $stable(owner_is_dbg)));

    p_disconnect_r7: assert property (@(posedge clk) disable iff (rst)
        (owner_is_dbg && dbg_disconnect) |=> !owned);

    p_cpu_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!cpu1_en && !cpu2_en && !msg_valid) |=> !msg_valid);

    p_dbg_implies_owned_r7: assert property (@(posedge clk) disable iff (rst)
        owner_is_dbg |-> owned);

    logic unused_in;
    assign unused_in = wr_valid ^ ^wr_size;

endmodule

bind trace_win_encoder trace_win_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_valid       (wr_valid),
    .wr_size        (wr_size),
    .cpu1_en        (cpu1_en),
    .cpu2_en        (cpu2_en),
    .claim_req      (claim_req),
    .claim_release  (claim_release),
    .dbg_disconnect (dbg_disconnect),
    .ovf_clear      (ovf_clear),
    .owned          (owned),
    .owner_is_dbg   (owner_is_dbg),
    .ovf_flag       (ovf_flag),
    .msg_valid      (msg_valid),
    .msg_ready      (msg_ready),
    .msg_hdr        (msg_hdr),
    .msg_data       (msg_data),
    .msg_tstamp     (msg_tstamp)
);

// File: tb/trace_win_encoder_tb.sv
module trace_win_encoder_tb;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        wr_valid, wr_from_dbg;
    logic [31:0] wr_addr, wr_data;
    logic [1:0]  wr_size;
    logic        cpu1_en, cpu2_en, dbg_trace_en;
    logic        claim_req, claim_is_dbg, claim_release, dbg_disconnect, dbg_halted;
    logic        ovf_clear;
    logic        owned, owner_is_dbg, ovf_flag, msg_valid;
    logic        drain;
    logic [11:0] msg_hdr;
    logic [31:0] msg_data;
    logic [15:0] msg_tstamp;

    trace_win_encoder #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size),
        .wr_from_dbg(wr_from_dbg), .cpu1_en(cpu1_en), .cpu2_en(cpu2_en),
        .dbg_trace_en(dbg_trace_en), .claim_req(claim_req), .claim_is_dbg(claim_is_dbg),
        .claim_release(claim_release), .dbg_disconnect(dbg_disconnect),
        .dbg_halted(dbg_halted), .ovf_clear(ovf_clear),
        .owned(owned), .owner_is_dbg(owner_is_dbg), .ovf_flag(ovf_flag),
        .msg_valid(msg_valid), .msg_ready(drain),
        .msg_hdr(msg_hdr), .msg_data(msg_data), .msg_tstamp(msg_tstamp)
    );

    int errors = 0;
    int checks = 0;
    logic [43:0] expq[$];
    bit model_owned = 0;
    bit model_dbg   = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares each message as it is taken
    always @(negedge clk) begin
        if (!rst && msg_valid && drain) begin
            if (expq.size() == 0) begin
                check(1'b0, "R1 unexpected message", {msg_hdr, msg_data}, 0);
            end else begin
                logic [43:0] e;
                e = expq.pop_front();
                check({msg_hdr, msg_data} == e, "R2 message header and payload",
                      {msg_hdr, msg_data}, e);
                check(msg_tstamp == 16'h0, "R6 timestamp zero", msg_tstamp, 0);
            end
        end
    end

    // driver: one store, expectation computed from the requirements
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                      input bit dbg);
        bit acc;
        logic [31:0] dz;
        wr_valid = 1; wr_addr = a; wr_data = d; wr_size = sz; wr_from_dbg = dbg;
        acc = (a[31:20] == 12'h546) && (sz != 2'b11) && model_owned &&
              (a[11] ? cpu2_en : cpu1_en) && (!dbg || dbg_trace_en);
        dz = (sz == 2'b00) ? {24'h0, d[7:0]} : (sz == 2'b01) ? {16'h0, d[15:0]} : d;
        if (acc && expq.size() < DEPTH)
            expq.push_back({a[10], a[11], sz, a[19:12], dz});
        @(posedge clk); #2;
        wr_valid = 0; wr_from_dbg = 0;
    endtask

    task automatic pulse_claim(input bit is_dbg);
        claim_req = 1; claim_is_dbg = is_dbg;
        @(posedge clk); #2;
        claim_req = 0; claim_is_dbg = 0;
        if (!model_owned) begin model_owned = 1; model_dbg = is_dbg; end
    endtask

    task automatic pulse_release();
        claim_release = 1;
        @(posedge clk); #2;
        claim_release = 0;
        model_owned = 0; model_dbg = 0;
    endtask

    task automatic pulse_disconnect();
        dbg_disconnect = 1;
        @(posedge clk); #2;
        dbg_disconnect = 0;
        if (model_dbg) begin model_owned = 0; model_dbg = 0; end
    endtask

    task automatic drain_all(input string req);
        drain = 1;
        for (int i = 0; i < 200 && expq.size() != 0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
        check(expq.size() == 0, req, expq.size(), 0);
        check(msg_valid == 1'b0, req, msg_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; wr_valid = 0; wr_addr = 0; wr_data = 0; wr_size = 0; wr_from_dbg = 0;
        cpu1_en = 1; cpu2_en = 1; dbg_trace_en = 0;
        claim_req = 0; claim_is_dbg = 0; claim_release = 0; dbg_disconnect = 0;
        dbg_halted = 0; ovf_clear = 0; drain = 1;
        repeat (3) @(posedge clk); #2;
        rst = 0;
        @(negedge clk);
        check({msg_valid, owned, owner_is_dbg, ovf_flag} == 4'b0, "R10 reset state",
              {msg_valid, owned, owner_is_dbg, ovf_flag}, 0);
        @(posedge clk); #2;

        // R7: no owner, store ignored
        wr(32'h5460_0000, 32'h1111_1111, 2'b10, 0);
        drain_all("R7 no message without owner");

        pulse_claim(0);
        check(owned && !owner_is_dbg, "R7 application claim", {owned, owner_is_dbg}, 2'b10);

        // R1 R2 R3: quarters, sizes, window edges
        wr(32'h5460_0000, 32'hCAFE_F00D, 2'b10, 0);
        wr(32'h546F_FC00, 32'hAABB_CCDD, 2'b00, 0);
        wr(32'h545A_07FE, 32'h1234_5678, 2'b01, 0);
        wr(32'h5465_A7FC, 32'h8765_4321, 2'b01, 0);
        wr(32'h5461_0800, 32'h0000_00A5, 2'b10, 0);
        wr(32'h5470_0000, 32'hDEAD_0001, 2'b10, 0);
        wr(32'h545F_FFFC, 32'hDEAD_0002, 2'b10, 0);
        wr(32'h5462_0000, 32'hDEAD_0003, 2'b11, 0);
        drain_all("R1 R3 window and size filtering");

        // R4: per-CPU enables
        cpu1_en = 0;
        wr(32'h5463_0000, 32'h0000_0C11, 2'b10, 0);
        wr(32'h5463_0C00, 32'h0000_0C22, 2'b10, 0);
        cpu1_en = 1; cpu2_en = 0;
        wr(32'h5463_0800, 32'h0000_0C33, 2'b10, 0);
        wr(32'h5463_0400, 32'h0000_0C44, 2'b10, 0);
        cpu2_en = 1;
        drain_all("R4 CPU enables");

        // R5: debugger gate
        wr(32'h5464_0000, 32'h0000_0D01, 2'b10, 1);
        dbg_trace_en = 1;
        wr(32'h5464_0C00, 32'h0000_0D02, 2'b10, 1);
        dbg_trace_en = 0;
        drain_all("R5 debugger gate");

        // R7: debug state has no effect, disconnect leaves app claim
        dbg_halted = 1;
        repeat (3) @(posedge clk); #2;
        check(owned && !owner_is_dbg, "R7 debug state ignored", owned, 1);
        dbg_halted = 0;
        pulse_disconnect();
        check(owned, "R7 disconnect keeps app claim", owned, 1);

        // R9: overflow, ordering, sticky flag
        drain = 0;
        check(ovf_flag == 0, "R9 no overflow before full", ovf_flag, 0);
        for (int i = 0; i < DEPTH + 2; i++)
            wr(32'h5466_0000 + 32'(i << 12), 32'h100 + 32'(i), 2'b10, 0);
        @(negedge clk);
        check(ovf_flag == 1, "R9 overflow flag set", ovf_flag, 1);
        check(msg_valid == 1, "R9 queue holds messages", msg_valid, 1);
        repeat (2) @(posedge clk); #2;
        check(ovf_flag == 1, "R9 overflow flag sticky", ovf_flag, 1);
        ovf_clear = 1;
        @(posedge clk); #2;
        ovf_clear = 0;
        check(ovf_flag == 0, "R9 overflow cleared", ovf_flag, 0);
        drain_all("R9 in-order drain after overflow");

        // R8: release with queued messages
        drain = 0;
        wr(32'h5467_0000, 32'h0000_0E01, 2'b10, 0);
        wr(32'h5467_0400, 32'h0000_0E02, 2'b00, 0);
        wr(32'h5467_0800, 32'h0000_0E03, 2'b01, 0);
        pulse_release();
        check(!owned, "R7 release frees claim", owned, 0);
        wr(32'h5467_0000, 32'h0000_0E04, 2'b10, 0);
        drain_all("R8 drain continues after release");

        // R7: debugger claim released by disconnect
        pulse_claim(1);
        check(owned && owner_is_dbg, "R7 debugger claim", {owned, owner_is_dbg}, 2'b11);
        pulse_claim(0);
        check(owner_is_dbg, "R7 claim ignored while owned", owner_is_dbg, 1);
        wr(32'h5468_0000, 32'h0000_0F01, 2'b10, 0);
        pulse_disconnect();
        check(!owned, "R7 disconnect frees debugger claim", owned, 0);
        wr(32'h5468_0000, 32'h0000_0F02, 2'b10, 0);
        drain_all("R7 messages after disconnect");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule